// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date as a ripple of packed-BCD counters. A single-cycle `tick` pulse, which the surrounding logic raises 100 times per second, advances the hundredths register. Each counter that wraps passes a carry to the next one: seconds, minutes, hours, then the day-of-week and day-of-month pair, then month and year. The hours register runs in a 12-hour format with an afternoon flag or in a 24-hour format, and the mode bit sits inside the hours byte itself. The month byte carries a century flag that flips each time the year wraps.

The host sets any register with a one-byte write on a valid/ready port. `wr_ready` is held high, so the block never applies back-pressure and every cycle with `wr_valid` high loads one byte. All eight registers are always visible on parallel output ports.

Top module: `bcd_clock_calendar`

## Requirements
- R1: After reset, the outputs read hsec 00, sec 00, min 00, hour 00 (24-hour mode), wday 01, date 01, month 01 with the century bit clear, and year 00.
- R2: On a tick, hundredths step through BCD 00..99, and seconds and minutes step through 00..59. Each wraps to 00 and then carries into the next register.
- R3: When hours bit 6 is 0, hours count 00..23 in BCD, with bit 5 used as the twenties digit. A step from 23 to 00 advances the day. Plain counting never changes bit 6.
- R4: When hours bit 6 is 1, bits 4:0 count 12, 01, 02 .. 11 and bit 5 is the PM flag. That flag flips only on the step from 11 to 12. The step from 11 PM to 12 AM advances the day.
- R5: Each day advance steps the weekday through 1..7, wrapping to 1, and steps the date by one.
- R6: The date wraps to 01 after 31 for months 01, 03, 05, 07, 08, 10 and 12, and after 30 for months 04, 06, 09 and 11. In month 02 it wraps after 29 when the BCD year is a multiple of 4, and after 28 otherwise. A date wrap advances the month.
- R7: The month (bits 4:0 of the month byte) steps 01..12. A wrap from 12 to 01 advances the year. A year wrap from 99 to 00 toggles the century flag, bit 7 of the month byte.
- R8: When `wr_valid` is high, the byte is written to the register selected by `wr_addr`: 0 hsec, 1 sec, 2 min, 3 hour, 4 wday, 5 date, 6 month, 7 year. Bits outside each register's field read as zero (for example, wday keeps bits 2:0 only). `wr_ready` is always 1.
- R9: When a write and an increment hit the same register in one cycle, the written byte is kept and the increment is dropped. The carry that the old value would have produced still reaches the next register.
- R10: In a cycle with no tick and no write, every register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 100 Hz advance pulse |
| wr_valid | input | 1 | Host byte write request |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Byte to load |
| hsec | output | 8 | Hundredths, BCD |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 8 | Hours, mode bit 6, PM/twenties bit 5 |
| wday | output | 8 | Weekday 1..7 |
| date | output | 8 | Day of month, BCD |
| month | output | 8 | Month BCD, century flag bit 7 |
| year | output | 8 | Year, BCD |

## Verification
The main patterns load a full time and date, apply one tick, and compare all eight bytes. A plain hundredths step shows that no false carry occurs. A seconds-only wrap and an hour-only wrap show that the ripple stops at the right register. Full wraps at the end of a day, month and year confirm that the chain runs through to the century flag. The 12-hour cases (11 AM, 12 PM, 11 PM, 12 AM) separate the flag flip from the day advance. The February cases in leap and non-leap years, together with 30-day months, show that the month length, and not a fixed limit, decides the date wrap. Write-collision cases confirm that the written byte wins while the carry still passes on.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int NREG   = 1 << ADDR_W;

  typedef enum logic [ADDR_W-1:0] {
    RA_HSEC = 3'd0, RA_SEC = 3'd1, RA_MIN = 3'd2, RA_HOUR = 3'd3,
    RA_WDAY = 3'd4, RA_DATE = 3'd5, RA_MON = 3'd6, RA_YEAR = 3'd7
  } reg_sel_e;

  function automatic logic [BYTE_W-1:0] bcd_next(input logic [BYTE_W-1:0] v);
    if (v[3:0] == 4'h9) bcd_next = {v[7:4] + 4'h1, 4'h0};
    else                bcd_next = {v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic logic year_is_leap(input logic [BYTE_W-1:0] yr);
    logic [5:0] s;
    s = {1'b0, yr[7:4], 1'b0} + {2'b0, yr[3:0]};
    year_is_leap = (s[1:0] == 2'b00);
  endfunction

  function automatic logic [BYTE_W-1:0] month_days(input logic [4:0] m,
                                                    input logic [BYTE_W-1:0] yr);
    case (m)
      5'h02:                      month_days = year_is_leap(yr) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: month_days = 8'h30;
      default:                    month_days = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_wrap_counter.sv
module bcd_wrap_counter
  import bcd_cal_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LOW  = 8'h00,
  parameter logic [BYTE_W-1:0] MASK = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic [BYTE_W-1:0] limit,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] value,
  output logic              carry
);
  logic [BYTE_W-1:0] cnt_q, cnt_d;

  assign carry = inc && (cnt_q >= limit);
  assign value = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en)      cnt_d = wr_data & MASK;
    else if (carry) cnt_d = LOW;
    else if (inc)   cnt_d = bcd_next(cnt_q) & MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= LOW;
    else        cnt_q <= cnt_d;
  end

  assert_wrap_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && !wr_en) |=> (value == LOW));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr_en) |=> $stable(value));
  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (value == ($past(wr_data) & MASK)));
endmodule

// File: rtl/hour_counter.sv
module hour_counter
  import bcd_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] hour,
  output logic              day_carry
);
  localparam logic [BYTE_W-1:0] HMASK = 8'h7F;

  logic [BYTE_W-1:0] hr_q, hr_d, step12, v12;
  logic mode12, pm;

  assign mode12 = hr_q[6];
  assign pm     = hr_q[5];
  assign v12    = {3'b000, hr_q[4:0]};
  assign step12 = bcd_next(v12);
  assign hour   = hr_q;

  always_comb begin
    day_carry = 1'b0;
    hr_d      = hr_q;
    if (mode12) begin
      day_carry = inc && pm && (v12 == 8'h11);
      if (inc) begin
        if (v12 >= 8'h12)      hr_d = {1'b0, 1'b1, pm, 5'h01};
        else if (v12 == 8'h11) hr_d = {1'b0, 1'b1, ~pm, 5'h12};
        else                   hr_d = {1'b0, 1'b1, pm, step12[4:0]};
      end
    end else begin
      day_carry = inc && ({2'b00, hr_q[5:0]} >= 8'h23);
      if (day_carry)  hr_d = 8'h00;
      else if (inc)   hr_d = bcd_next({2'b00, hr_q[5:0]}) & 8'h3F;
    end
    if (wr_en) hr_d = wr_data & HMASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hr_q <= 8'h00;
    else        hr_q <= hr_d;
  end

  assert_pm_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en && hour[6] && hour[4:0] == 5'h11) |=> (hour[5] != $past(hour[5])));
  assert_pm_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en && hour[6] && hour[4:0] != 5'h11) |=> $stable(hour[5]));
  assert_mode_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en) |=> $stable(hour[6]));
  assert_midnight_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && !wr_en && !hour[6]) |=> (hour == 8'h00));
endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
  import bcd_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] hsec,
  output logic [BYTE_W-1:0] sec,
  output logic [BYTE_W-1:0] min,
  output logic [BYTE_W-1:0] hour,
  output logic [BYTE_W-1:0] wday,
  output logic [BYTE_W-1:0] date,
  output logic [BYTE_W-1:0] month,
  output logic [BYTE_W-1:0] year
);
  localparam int NTIME = 3;
  localparam logic [BYTE_W-1:0] TLIM  [NTIME] = '{8'h99, 8'h59, 8'h59};
  localparam logic [BYTE_W-1:0] TMASK [NTIME] = '{8'hFF, 8'h7F, 8'h7F};

  logic [NREG-1:0]   we;
  logic [NTIME:0]    tc;
  logic [BYTE_W-1:0] tval [NTIME];
  logic              day_c, date_c, wday_c, mon_c, year_c;
  logic [BYTE_W-1:0] mon_f, date_lim;
  logic              cent_q;

  assign wr_ready = 1'b1;
  assign we       = wr_valid ? (NREG'(1) << wr_addr) : '0;
  assign tc[0]    = tick;

  for (genvar i = 0; i < NTIME; i++) begin : g_time
    bcd_wrap_counter #(.LOW(8'h00), .MASK(TMASK[i])) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(tc[i]), .limit(TLIM[i]),
      .wr_en(we[i]), .wr_data(wr_data), .value(tval[i]), .carry(tc[i+1])
    );
  end

  assign hsec = tval[0];
  assign sec  = tval[1];
  assign min  = tval[2];

  hour_counter u_hour (
    .clk(clk), .rst_n(rst_n), .inc(tc[NTIME]), .wr_en(we[RA_HOUR]),
    .wr_data(wr_data), .hour(hour), .day_carry(day_c)
  );

  bcd_wrap_counter #(.LOW(8'h01), .MASK(8'h07)) u_wday (
    .clk(clk), .rst_n(rst_n), .inc(day_c), .limit(8'h07),
    .wr_en(we[RA_WDAY]), .wr_data(wr_data), .value(wday), .carry(wday_c)
  );

  assign date_lim = month_days(mon_f[4:0], year);

  bcd_wrap_counter #(.LOW(8'h01), .MASK(8'h3F)) u_date (
    .clk(clk), .rst_n(rst_n), .inc(day_c), .limit(date_lim),
    .wr_en(we[RA_DATE]), .wr_data(wr_data), .value(date), .carry(date_c)
  );

  bcd_wrap_counter #(.LOW(8'h01), .MASK(8'h1F)) u_mon (
    .clk(clk), .rst_n(rst_n), .inc(date_c), .limit(8'h12),
    .wr_en(we[RA_MON]), .wr_data(wr_data), .value(mon_f), .carry(mon_c)
  );

  bcd_wrap_counter #(.LOW(8'h00), .MASK(8'hFF)) u_year (
    .clk(clk), .rst_n(rst_n), .inc(mon_c), .limit(8'h99),
    .wr_en(we[RA_YEAR]), .wr_data(wr_data), .value(year), .carry(year_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           cent_q <= 1'b0;
    else if (we[RA_MON])  cent_q <= wr_data[7];
    else if (year_c)      cent_q <= ~cent_q;
  end

  assign month = {cent_q, 2'b00, mon_f[4:0]};

  assert_century_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (year_c && !we[RA_MON]) |=> (month[7] != $past(month[7])));
  assert_century_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!year_c && !we[RA_MON]) |=> $stable(month[7]));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_valid) |=> $stable({hsec, sec, min, hour, wday, date, month, year}));
  assert_day_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (day_c && !we[RA_WDAY]) |=> !$stable(wday));
  assert_one_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));
endmodule

// File: tb/tb_bcd_clock_calendar.sv
module tb_bcd_clock_calendar;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] hsec, sec, min, hour, wday, date, month, year;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bcd_clock_calendar dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsec(hsec), .sec(sec), .min(min), .hour(hour), .wday(wday),
    .date(date), .month(month), .year(year)
  );

  // bytes: year month date wday hour min sec hsec | expected after one tick
  localparam int NV = 15;
  localparam logic [127:0] VEC [NV] = '{
    128'h00010101_00000000_00010101_00000001, // R2 plain step
    128'h99123107_23595999_00810101_00000000, // R7 full wrap to century
    128'h24061503_09595999_24061503_10000000, // R3 hour step only
    128'h24061503_51595999_24061503_72000000, // R4 11 AM -> 12 PM
    128'h24061503_72595999_24061503_61000000, // R4 12 PM -> 1 PM
    128'h24061503_71595999_24061604_52000000, // R4 11 PM -> 12 AM, day
    128'h23022802_23595999_23030103_00000000, // R6 Feb non-leap
    128'h24022802_23595999_24022903_00000000, // R6 Feb leap
    128'h24022905_23595999_24030106_00000000, // R6 Feb 29 end
    128'h24043007_23595999_24050101_00000000, // R5 30-day month, weekday wrap
    128'h24093001_23595999_24100102_00000000, // R6 month 09 -> 10
    128'h99923104_23595999_00010105_00000000, // R7 century clears
    128'h24061503_52595999_24061503_41000000, // R4 12 AM -> 1 AM
    128'h24061503_10123456_24061503_10123457, // R2 hsec only
    128'h24061503_10125999_24061503_10130000  // R2 seconds wrap into minutes
  };

  function automatic string vtag(input int i);
    case (i)
      1, 11:          vtag = "R7";
      2:              vtag = "R3";
      3, 4, 5, 12:    vtag = "R4";
      6, 7, 8, 10:    vtag = "R6";
      9:              vtag = "R5";
      default:        vtag = "R2";
    endcase
  endfunction

  function automatic logic [63:0] snap();
    snap = {year, month, date, wday, hour, min, sec, hsec};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic load(input logic [63:0] s);
    for (int k = 0; k < 8; k++) wr(3'(k), s[8*k +: 8]);
  endtask

  task automatic pulse();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", snap(), 64'h00010101_00000000);
    check("R8 ready", {63'b0, wr_ready}, 64'h1);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i][127:64]);
      pulse();
      check(vtag(i), snap(), VEC[i][63:0]);
    end

    // R10: idle cycles keep every register
    load(64'h24061503_10123456);
    repeat (20) @(negedge clk);
    check("R10 idle hold", snap(), 64'h24061503_10123456);

    // R8: field masking on write
    wr(3'd4, 8'hF3);
    check("R8 wday mask", {56'b0, wday}, 64'h03);
    wr(3'd6, 8'hE5);
    check("R8 month mask", {56'b0, month}, 64'h85);

    // R9: write and tick together on hsec
    load(64'h24061503_10121099);
    @(negedge clk);
    tick = 1'b1; wr_valid = 1'b1; wr_addr = 3'd0; wr_data = 8'h42;
    @(negedge clk);
    tick = 1'b0; wr_valid = 1'b0;
    check("R9 collision carry", snap(), 64'h24061503_10121142);

    load(64'h24061503_10121010);
    @(negedge clk);
    tick = 1'b1; wr_valid = 1'b1; wr_addr = 3'd0; wr_data = 8'h50;
    @(negedge clk);
    tick = 1'b0; wr_valid = 1'b0;
    check("R9 collision no carry", snap(), 64'h24061503_10121050);

    // R1: reset again from a loaded state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 re-reset", snap(), 64'h00010101_00000000);

    // R2: 100 ticks equal one second
    for (int k = 0; k < 100; k++) pulse();
    check("R2 hundred ticks", snap(), 64'h00010101_00000100);

    finish_run();
  end
endmodule